// File: doc/BRIEF.md
# Programmable Raster Timing Generator with Borders

This block derives horizontal and vertical raster timing from start positions that software writes into a small 32-bit register bank. Each line, and likewise each frame, passes in a fixed order through sync, back porch, a leading border, active display, a trailing border and front porch. Every boundary between two regions has its own programmable start position, and the total length closes the front porch.

The outputs are hsync and vsync with selectable polarity, a blank flag, a border flag, an active-display flag and the current pixel and line counts. All of them leave the same output register, so they always describe the same (pixel, line) position. A global enable starts the generator, and each axis can be halted on its own. Timing values are copied into shadow registers only at frame boundaries, or while the generator is stopped. A frame therefore never mixes old and new timing.

Top module: `vtiming_gen`

## Requirements
- R1: The register bank is addressed as 0 = control, 1/2/3 = horizontal registers 1/2/3, 4/5/6 = vertical registers 1/2/3. Each timing register stores two 12-bit fields, at bits 11:0 and bits 27:16, and all its other bits read as zero. `rd_data` returns the register selected by `rd_addr` one clock later.
- R2: In register 1, the low field is the total (pixels per line or lines per frame) and the high field is the back-porch start. In register 2, the low field is the leading-border start and the high field is the active start. In register 3, the low field is the trailing-border start and the high field is the front-porch start.
- R3: Control bit 31 enables the generator, bit 0 halts the horizontal axis and bit 2 halts the vertical axis. Bits 1 and 3 are the hsync and vsync polarity. All other control bits read as zero.
- R4: The pixel counter runs from 0 to total-1 and then wraps to 0. The line counter advances by one when a line wraps, and returns to 0 after line total-1.
- R5: Sync is asserted from count 0 up to, but not including, the back-porch start. The regions then follow each other in order, each ending where the next programmed start begins.
- R6: A set polarity bit gives an active-high sync pulse. A clear polarity bit gives an active-low pulse, and the opposite level is driven outside the pulse.
- R7: `active` is high only when both axes are inside active display. `blank` is its inverse.
- R8: `border` is high when one axis is in its leading or trailing border while the other axis is between its leading-border start and its front-porch start.
- R9: When the generator is disabled, both counters are held at zero. When an axis is halted, its counter is held at zero. In both cases the affected sync output stays at its inactive level.
- R10: A write to a timing register reads back at once but takes effect only at the start of the next frame.
- R11: Sync, blank, border and active are registered together with `pix_x` and `line_y` and describe the position those two outputs show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | High outside active display |
| border | output | 1 | High inside a border region |
| active | output | 1 | High inside active display |
| pix_x | output | 12 | Current pixel count |
| line_y | output | 12 | Current line count |

## Verification
The bench builds the block with its default 12-bit field width and programs a miniature raster of 20 pixels by 10 lines, in which every region is between one and eight counts long. One whole frame then lasts only 200 clocks. This short frame puts every region boundary, line and frame wraps, both polarities, halts, and the deferred effect of a mid-frame write within a few thousand cycles.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int FLD_W = 12;
  localparam int REG_W = 32;
  localparam int LO_POS = 0;
  localparam int HI_POS = 16;

  localparam int CTL_HHALT = 0;
  localparam int CTL_HPOL  = 1;
  localparam int CTL_VHALT = 2;
  localparam int CTL_VPOL  = 3;
  localparam int CTL_EN    = 31;

  typedef logic [FLD_W-1:0] fld_t;

  typedef struct packed {
    fld_t total;
    fld_t sync_end;
    fld_t lead_brd;
    fld_t act_start;
    fld_t trail_brd;
    fld_t fp_start;
  } axis_cfg_t;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_H1   = 3'd1,
    A_H2   = 3'd2,
    A_H3   = 3'd3,
    A_V1   = 3'd4,
    A_V2   = 3'd5,
    A_V3   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int N_TREGS = 6,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [REG_W-1:0] rd_data,
  output axis_cfg_t        cfg_h,
  output axis_cfg_t        cfg_v,
  output logic             en,
  output logic             h_halt,
  output logic             v_halt,
  output logic             h_pol,
  output logic             v_pol
);
  localparam int PAD = HI_POS - FLD_W;

  fld_t lo_q [N_TREGS];
  fld_t hi_q [N_TREGS];
  logic [REG_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; h_halt <= 1'b0; v_halt <= 1'b0; h_pol <= 1'b0; v_pol <= 1'b0;
      for (int i = 0; i < N_TREGS; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == AW'(A_CTRL)) begin
        en     <= wr_data[CTL_EN];
        h_halt <= wr_data[CTL_HHALT];
        v_halt <= wr_data[CTL_VHALT];
        h_pol  <= wr_data[CTL_HPOL];
        v_pol  <= wr_data[CTL_VPOL];
      end
      for (int i = 0; i < N_TREGS; i++) begin
        if (wr_addr == AW'(i + 1)) begin
          lo_q[i] <= wr_data[LO_POS +: FLD_W];
          hi_q[i] <= wr_data[HI_POS +: FLD_W];
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == AW'(A_CTRL)) begin
      rd_mux[CTL_EN]    = en;
      rd_mux[CTL_HHALT] = h_halt;
      rd_mux[CTL_VHALT] = v_halt;
      rd_mux[CTL_HPOL]  = h_pol;
      rd_mux[CTL_VPOL]  = v_pol;
    end
    for (int i = 0; i < N_TREGS; i++) begin
      if (rd_addr == AW'(i + 1))
        rd_mux = {{PAD{1'b0}}, hi_q[i], {PAD{1'b0}}, lo_q[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // Live (unshadowed) timing set, register 1/2/3 per axis
  assign cfg_h = '{total: lo_q[0], sync_end: hi_q[0], lead_brd: lo_q[1],
                   act_start: hi_q[1], trail_brd: lo_q[2], fp_start: hi_q[2]};
  assign cfg_v = '{total: lo_q[3], sync_end: hi_q[3], lead_brd: lo_q[4],
                   act_start: hi_q[4], trail_brd: lo_q[5], fp_start: hi_q[5]};

  // R1 / R3: reserved read bits stay zero
  always @(posedge clk) begin
    if (!rst) begin
      p_rsvd_zero_r1: assert (rd_data[15:12] == 4'b0 && rd_data[30:28] == 3'b0)
        else $error("reserved read bits set");
    end
  end
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
#(
  parameter int W = FLD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          step,
  input  axis_cfg_t     cfg,
  output logic [W-1:0]  cnt,
  output logic          wrap,
  output logic          in_sync,
  output logic          in_border,
  output logic          in_active,
  output logic          in_span
);
  logic last;

  assign last = ({1'b0, cnt} + (W+1)'(1)) >= {1'b0, cfg.total};
  assign wrap = run && step && last;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (step)   cnt <= last ? '0 : cnt + W'(1);
  end

  assign in_sync   = cnt < cfg.sync_end;
  assign in_active = (cnt >= cfg.act_start) && (cnt < cfg.trail_brd);
  assign in_border = ((cnt >= cfg.lead_brd) && (cnt < cfg.act_start)) ||
                     ((cnt >= cfg.trail_brd) && (cnt < cfg.fp_start));
  assign in_span   = (cnt >= cfg.lead_brd) && (cnt < cfg.fp_start);

  p_halt_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (run && step && last) |=> cnt == '0);
  p_step_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (run && step && !last) |=> cnt == W'($past(cnt) + W'(1)));
endmodule

// File: rtl/vtiming_gen.sv
module vtiming_gen
  import rtg_pkg::*;
#(
  parameter int AW = 3,
  parameter int CW = FLD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          hsync,
  output logic          vsync,
  output logic          blank,
  output logic          border,
  output logic          active,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] line_y
);
  axis_cfg_t live_h, live_v, sh_h, sh_v;
  logic en, h_halt, v_halt, h_pol, v_pol;
  logic h_run, v_run, h_load, v_load;
  logic [CW-1:0] hcnt, vcnt;
  logic h_wrap, v_wrap;
  logic h_sync, h_brd, h_act, h_span;
  logic v_sync, v_brd, v_act, v_span;

  rtg_regs #(.N_TREGS(6), .AW(AW)) regs_i (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .cfg_h(live_h), .cfg_v(live_v), .en, .h_halt, .v_halt, .h_pol, .v_pol
  );

  assign h_run = en && !h_halt;
  assign v_run = en && !v_halt;

  // Shadow update: frame boundary, or whenever that axis is stopped.
  // With the vertical axis halted, the horizontal set follows line ends.
  assign h_load = !h_run || v_wrap || (!v_run && h_wrap);
  assign v_load = !v_run || v_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_h <= '0;
      sh_v <= '0;
    end else begin
      if (h_load) sh_h <= live_h;
      if (v_load) sh_v <= live_v;
    end
  end

  rtg_axis #(.W(CW)) h_axis_i (
    .clk, .rst, .run(h_run), .step(1'b1), .cfg(sh_h),
    .cnt(hcnt), .wrap(h_wrap), .in_sync(h_sync), .in_border(h_brd),
    .in_active(h_act), .in_span(h_span)
  );

  rtg_axis #(.W(CW)) v_axis_i (
    .clk, .rst, .run(v_run), .step(h_wrap), .cfg(sh_v),
    .cnt(vcnt), .wrap(v_wrap), .in_sync(v_sync), .in_border(v_brd),
    .in_active(v_act), .in_span(v_span)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_x <= '0; line_y <= '0;
      hsync <= 1'b1; vsync <= 1'b1;
      blank <= 1'b1; border <= 1'b0; active <= 1'b0;
    end else begin
      pix_x  <= hcnt;
      line_y <= vcnt;
      hsync  <= (h_run && h_sync) ? h_pol : ~h_pol;
      vsync  <= (v_run && v_sync) ? v_pol : ~v_pol;
      active <= h_act && v_act;
      blank  <= !(h_act && v_act);
      border <= (h_brd && v_span) || (v_brd && h_span);
    end
  end

  p_hsync_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !h_run |=> hsync == ~$past(h_pol));
  p_vsync_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !v_run |=> vsync == ~$past(v_pol));
  p_active_unblank_r7: assert property (@(posedge clk) disable iff (rst)
    active |-> !blank);
  p_border_blank_r8: assert property (@(posedge clk) disable iff (rst)
    border |-> (blank && !active));
endmodule

// File: tb/vtiming_gen_tb_top.sv
module vtiming_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        hsync, vsync, blank, border, active;
  logic [11:0] pix_x, line_y;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  vtiming_gen dut_i (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .hsync, .vsync, .blank, .border, .active, .pix_x, .line_y
  );

  typedef struct packed {
    logic [11:0] x;
    logic [11:0] y;
    logic hs, vs, bl, bd, ac;
  } vec_t;

  // Raster: H total 20, bp 2, lb 4, act 6, rb 14, fp 16
  //         V total 10, bp 1, tb 2, act 3, bb 7,  fp 8
  // hsync active-high, vsync active-low
  localparam vec_t VECS [12] = '{
    '{12'd0,  12'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{12'd6,  12'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{12'd4,  12'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{12'd14, 12'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{12'd8,  12'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{12'd8,  12'd7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{12'd17, 12'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{12'd2,  12'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{12'd13, 12'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{12'd1,  12'd9, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{12'd5,  12'd8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{12'd19, 12'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_xy(input logic [11:0] x, input logic [11:0] y, output bit found);
    found = 1'b0;
    for (int n = 0; n < 600 && !found; n++) begin
      @(negedge clk);
      if (pix_x == x && line_y == y) found = 1'b1;
    end
  endtask

  logic [31:0] r;
  bit ok;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state: counters zero, syncs at inactive level of polarity 0
    chk("R9", "reset pix_x", 32'(pix_x), 0);
    chk("R9", "reset line_y", 32'(line_y), 0);
    chk("R9", "reset hsync", 32'(hsync), 1);
    chk("R9", "reset vsync", 32'(vsync), 1);
    chk("R7", "reset blank", 32'(blank), 1);
    chk("R8", "reset border", 32'(border), 0);
    rd(3'd0, r);
    chk("R3", "reset ctrl read", r, 0);

    // Field masking
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, r);
    chk("R1", "H2 mask", r, 32'h0FFF_0FFF);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, r);
    chk("R3", "ctrl mask", r, 32'h8000_000F);
    wr(3'd0, 32'h0);

    // Program the raster
    wr(3'd1, (32'd2 << 16) | 32'd20);
    wr(3'd2, (32'd6 << 16) | 32'd4);
    wr(3'd3, (32'd16 << 16) | 32'd14);
    wr(3'd4, (32'd1 << 16) | 32'd10);
    wr(3'd5, (32'd3 << 16) | 32'd2);
    wr(3'd6, (32'd8 << 16) | 32'd7);
    rd(3'd3, r);
    chk("R2", "H3 readback", r, 32'h0010_000E);
    rd(3'd4, r);
    chk("R2", "V1 readback", r, 32'h0001_000A);

    wr(3'd0, 32'h8000_0002);

    // Vector table: R5 sync, R7 blank/active, R8 border, R11 alignment
    for (int i = 0; i < 12; i++) begin
      wait_xy(VECS[i].x, VECS[i].y, ok);
      chk("R4", $sformatf("reach v%0d", i), 32'(ok), 1);
      chk("R5", $sformatf("hsync v%0d", i), 32'(hsync), 32'(VECS[i].hs));
      chk("R5", $sformatf("vsync v%0d", i), 32'(vsync), 32'(VECS[i].vs));
      chk("R7", $sformatf("blank v%0d", i), 32'(blank), 32'(VECS[i].bl));
      chk("R8", $sformatf("border v%0d", i), 32'(border), 32'(VECS[i].bd));
      chk("R11", $sformatf("active v%0d", i), 32'(active), 32'(VECS[i].ac));
    end

    // Line advance and frame wrap
    wait_xy(12'd19, 12'd4, ok);
    @(negedge clk);
    chk("R4", "line advance x", 32'(pix_x), 0);
    chk("R4", "line advance y", 32'(line_y), 5);
    wait_xy(12'd19, 12'd9, ok);
    @(negedge clk);
    chk("R4", "frame wrap y", 32'(line_y), 0);

    // Inverted polarities
    wr(3'd0, 32'h8000_0008);
    wait_xy(12'd0, 12'd0, ok);
    chk("R6", "hsync low pulse", 32'(hsync), 0);
    chk("R6", "vsync high pulse", 32'(vsync), 1);
    wait_xy(12'd8, 12'd4, ok);
    chk("R6", "hsync idle high", 32'(hsync), 1);
    chk("R6", "vsync idle low", 32'(vsync), 0);

    // Horizontal halt
    wr(3'd0, 32'h8000_0009);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9", "h halt pix_x", 32'(pix_x), 0);
      chk("R9", "h halt hsync", 32'(hsync), 1);
    end

    // Vertical halt
    wr(3'd0, 32'h8000_000C);
    repeat (3) @(negedge clk);
    wait_xy(12'd10, 12'd0, ok);
    chk("R9", "v halt h runs", 32'(ok), 1);
    for (int k = 0; k < 40; k++) @(negedge clk);
    chk("R9", "v halt line_y", 32'(line_y), 0);
    chk("R9", "v halt vsync", 32'(vsync), 0);

    // Disabled
    wr(3'd0, 32'h0000_0002);
    repeat (3) @(negedge clk);
    chk("R9", "off pix_x", 32'(pix_x), 0);
    chk("R9", "off line_y", 32'(line_y), 0);
    chk("R9", "off hsync", 32'(hsync), 0);
    chk("R9", "off vsync", 32'(vsync), 1);

    // Shadowing of a mid-frame write
    wr(3'd0, 32'h8000_0002);
    wait_xy(12'd0, 12'd3, ok);
    wr(3'd1, (32'd2 << 16) | 32'd30);
    rd(3'd1, r);
    chk("R1", "H1 new readback", r, 32'h0002_001E);
    wait_xy(12'd19, 12'd5, ok);
    chk("R10", "old total reach", 32'(ok), 1);
    @(negedge clk);
    chk("R10", "old total wraps", 32'(pix_x), 0);
    wait_xy(12'd25, 12'd1, ok);
    chk("R10", "new total in next frame", 32'(ok), 1);
    chk("R10", "fp blank at x25", 32'(blank), 1);
    chk("R8", "fp no border x25", 32'(border), 0);

    summary();
  end
endmodule